// File: doc/BRIEF.md
# Partial-Width General Register File

This block holds sixteen 64-bit general-purpose registers. It has two read ports and one write port. Every port takes a register index and an operand-size code, so an access can select the whole register or only part of it. The parts are the low 32 bits, the low 16 bits, the low byte and, for the first four registers, the second byte (bits 15:8). A read returns the selected part right-aligned in a 64-bit result, with zeros above it.

Writes follow width-dependent rules. A 32-bit write zero-extends into the whole register. An 8-bit or 16-bit write merges into the old contents and leaves every other bit as it was. A 64-bit write replaces the register. Some selections are not allowed: a second-byte selection on a register above index 3, a second-byte selection while the extended operand form is active (`ext_form`), and any undefined size code. Each port flags these on its own. A flagged write changes nothing, and a flagged read returns zero.

Reads are combinational. Writes land on the rising clock edge. A read of the register being written in the same cycle sees the value from before the write.

Top module: `slice_rf`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen registers to zero.
- R2: Size code 4 (64-bit) writes all 64 bits of the register, and a size-4 read returns all 64 bits.
- R3: Size code 3 (32-bit) writes data bits 31:0 into register bits 31:0 and clears register bits 63:32. A size-3 read returns register bits 31:0 with output bits 63:32 at zero.
- R4: Size code 2 (16-bit) writes register bits 15:0 only, and bits 63:16 keep their old value. A size-2 read returns bits 15:0 with output bits 63:16 at zero.
- R5: Size code 0 (low byte) writes register bits 7:0 only, for any index 0 to 15, and bits 63:8 keep their old value. A size-0 read returns bits 7:0 zero-padded.
- R6: Size code 1 (high byte) on index 0 to 3 with `ext_form` low writes data bits 7:0 into register bits 15:8 and keeps all other bits. A size-1 read returns register bits 15:8 in output bits 7:0, with zeros above.
- R7: Size code 1 on index 4 to 15 is illegal. The port's bad flag is high, a write changes no register, and a read returns zero.
- R8: Size code 1 while `ext_form` is high is illegal on every index, with the same effect as R7.
- R9: Size codes 5, 6 and 7 are illegal on every port, with the same effect as R7.
- R10: A read of the register being written in the same cycle returns the value held before that write.
- R11: With `wr_en` low no register changes, and `wr_bad` stays low.
- R12: The two read ports select independently, and each has its own data and bad flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_form | input | 1 | Extended operand form active; high-byte selections are rejected |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write size code (0 lo8, 1 hi8, 2 16b, 3 32b, 4 64b) |
| wr_data | input | 64 | Write data, right-aligned |
| wr_bad | output | 1 | Write request has an illegal selection |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 3 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 result, right-aligned and zero-padded |
| rd0_bad | output | 1 | Read port 0 selection illegal |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 3 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 result, right-aligned and zero-padded |
| rd1_bad | output | 1 | Read port 1 selection illegal |

## Verification
The assertions assume that `wr_en` is low while `rst` is high. They also assume that index and size inputs change only away from the rising edge, so each one stays stable for a whole cycle. The bench drives every input on the falling edge and keeps the write request off throughout each reset pulse. It reaches each illegal case through a deliberate request: a high byte on index 4 or above, a high byte with `ext_form` high, and size codes 5 to 7. No illegal request comes from unsettled or unknown inputs.

// File: rtl/slice_rf_pkg.sv
package slice_rf_pkg;

  localparam int RF_W = 64;

  typedef enum logic [2:0] {
    SZ_LO8 = 3'd0,
    SZ_HI8 = 3'd1,
    SZ_W16 = 3'd2,
    SZ_W32 = 3'd3,
    SZ_W64 = 3'd4
  } sz_e;

  // Legality of one selection: size code in range, high byte only when allowed.
  function automatic logic sel_legal(logic [2:0] size, logic idx_has_hi, logic ext_form);
    logic known;
    known = (size <= SZ_W64);
    if (size == SZ_HI8) return idx_has_hi && !ext_form;
    return known;
  endfunction

  // Right-aligned, zero-padded view of a register for a given size.
  function automatic logic [RF_W-1:0] slice_read(logic [RF_W-1:0] r, logic [2:0] size);
    logic [RF_W-1:0] v;
    v = '0;
    case (size)
      SZ_LO8: v[7:0]  = r[7:0];
      SZ_HI8: v[7:0]  = r[15:8];
      SZ_W16: v[15:0] = r[15:0];
      SZ_W32: v[31:0] = r[31:0];
      SZ_W64: v       = r;
      default: v      = '0;
    endcase
    return v;
  endfunction

  // New register value after a write of the given size.
  function automatic logic [RF_W-1:0] slice_merge(logic [RF_W-1:0] old,
                                                  logic [RF_W-1:0] d,
                                                  logic [2:0]      size);
    logic [RF_W-1:0] n;
    n = old;
    case (size)
      SZ_LO8: n[7:0]  = d[7:0];
      SZ_HI8: n[15:8] = d[7:0];
      SZ_W16: n[15:0] = d[15:0];
      SZ_W32: n       = {32'd0, d[31:0]};
      SZ_W64: n       = d;
      default: n      = old;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/slice_rf_legal.sv
module slice_rf_legal
  import slice_rf_pkg::*;
#(
  parameter int NREGS   = 16,
  parameter int HI_REGS = 4,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       size,
  input  logic             ext_form,
  output logic             legal
);
  logic idx_has_hi;

  assign idx_has_hi = (int'(idx) < HI_REGS);
  assign legal      = sel_legal(size, idx_has_hi, ext_form);
endmodule

// File: rtl/slice_rf_port.sv
module slice_rf_port
  import slice_rf_pkg::*;
#(
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [RF_W-1:0]  regs [NREGS],
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       size,
  input  logic             legal,
  output logic [RF_W-1:0]  data
);
  logic [RF_W-1:0] picked;

  assign picked = regs[idx];
  assign data   = legal ? slice_read(picked, size) : '0;
endmodule

// File: rtl/slice_rf_bank.sv
module slice_rf_bank
  import slice_rf_pkg::*;
#(
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       size,
  input  logic [RF_W-1:0]  data,
  output logic [RF_W-1:0]  regs [NREGS]
);
  logic [RF_W-1:0] merged;

  assign merged = slice_merge(regs[idx], data, size);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[idx] <= merged;
    end
  end
endmodule

// File: rtl/slice_rf.sv
module slice_rf
  import slice_rf_pkg::*;
#(
  parameter int NREGS   = 16,
  parameter int HI_REGS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ext_form,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [2:0]               wr_size,
  input  logic [63:0]              wr_data,
  output logic                     wr_bad,
  input  logic [$clog2(NREGS)-1:0] rd0_idx,
  input  logic [2:0]               rd0_size,
  output logic [63:0]              rd0_data,
  output logic                     rd0_bad,
  input  logic [$clog2(NREGS)-1:0] rd1_idx,
  input  logic [2:0]               rd1_size,
  output logic [63:0]              rd1_data,
  output logic                     rd1_bad
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int NRD   = 2;

  logic [RF_W-1:0]  rf_q [NREGS];
  logic [IDX_W-1:0] rd_idx   [NRD];
  logic [2:0]       rd_size  [NRD];
  logic [RF_W-1:0]  rd_data  [NRD];
  logic             rd_legal [NRD];
  logic             wr_legal;
  logic             wr_commit;

  assign rd_idx[0]  = rd0_idx;
  assign rd_idx[1]  = rd1_idx;
  assign rd_size[0] = rd0_size;
  assign rd_size[1] = rd1_size;

  slice_rf_legal #(.NREGS(NREGS), .HI_REGS(HI_REGS)) u_wr_legal (
    .idx(wr_idx), .size(wr_size), .ext_form(ext_form), .legal(wr_legal)
  );

  assign wr_bad    = wr_en && !wr_legal;
  assign wr_commit = wr_en && wr_legal && !rst;

  slice_rf_bank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst(rst), .commit(wr_commit), .idx(wr_idx),
    .size(wr_size), .data(wr_data), .regs(rf_q)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    slice_rf_legal #(.NREGS(NREGS), .HI_REGS(HI_REGS)) u_legal (
      .idx(rd_idx[g]), .size(rd_size[g]), .ext_form(ext_form), .legal(rd_legal[g])
    );
    slice_rf_port #(.NREGS(NREGS)) u_port (
      .regs(rf_q), .idx(rd_idx[g]), .size(rd_size[g]),
      .legal(rd_legal[g]), .data(rd_data[g])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];
  assign rd0_bad  = !rd_legal[0];
  assign rd1_bad  = !rd_legal[1];
endmodule

// File: rtl/slice_rf_sva.sv
module slice_rf_sva #(
  parameter int NREGS   = 16,
  parameter int HI_REGS = 4,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_form,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [2:0]       wr_size,
  input logic             wr_bad,
  input logic             wr_commit,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [2:0]       rd0_size,
  input logic [63:0]      rd0_data,
  input logic             rd0_bad,
  input logic [63:0]      rd1_data,
  input logic             rd1_bad,
  input logic [63:0]      rf_q [NREGS]
);
  // R3: a committed 32-bit write leaves the upper half at zero
  a_r3_w32_clears_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == 3'd3) |=> rf_q[$past(wr_idx)][63:32] == 32'd0);

  // R5: a committed low-byte write keeps bits 63:8
  a_r5_lo8_keeps_rest: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == 3'd0) |=> rf_q[$past(wr_idx)][63:8] == $past(rf_q[wr_idx][63:8]));

  // R6: a legal high-byte read has nothing above bit 7
  a_r6_hi_read_narrow: assert property (@(posedge clk) disable iff (rst)
    (!rd0_bad && rd0_size == 3'd1) |-> rd0_data[63:8] == 56'd0);

  // R7: a high-byte write on an index without one is rejected
  a_r7_hi_index_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 3'd1 && int'(wr_idx) >= HI_REGS) |-> (wr_bad && !wr_commit));

  // R7: rejected reads on either port return zero
  a_r7_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd0_bad |-> rd0_data == 64'd0) and (rd1_bad |-> rd1_data == 64'd0));

  // R8: the extended form rejects a high-byte read
  a_r8_hi_ext_flag: assert property (@(posedge clk) disable iff (rst)
    (rd0_size == 3'd1 && ext_form) |-> rd0_bad);

  // R9: undefined size codes are rejected on the write port
  a_r9_size_code_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size > 3'd4) |-> wr_bad);

  // R11: without a write request the register seen by read port 0 holds its value
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (rf_q[$past(rd0_idx)] == $past(rf_q[rd0_idx]) && !$past(wr_bad)));
endmodule

bind slice_rf slice_rf_sva #(.NREGS(NREGS), .HI_REGS(HI_REGS)) u_sva (
  .clk(clk), .rst(rst), .ext_form(ext_form), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_size(wr_size), .wr_bad(wr_bad), .wr_commit(wr_commit),
  .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_bad(rd0_bad),
  .rd1_data(rd1_data), .rd1_bad(rd1_bad), .rf_q(rf_q)
);

// File: tb/slice_rf_tb.sv
module slice_rf_tb;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        ext_form = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [2:0]  wr_size = 0;
  logic [63:0] wr_data = 0;
  logic        wr_bad;
  logic [3:0]  rd0_idx = 0, rd1_idx = 0;
  logic [2:0]  rd0_size = 4, rd1_size = 4;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_bad, rd1_bad;

  int checks = 0;
  int errors = 0;
  logic [63:0] mdl [16];

  always #(CLK_P/2) clk = ~clk;

  slice_rf u_dut (
    .clk(clk), .rst(rst), .ext_form(ext_form), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_data(wr_data), .wr_bad(wr_bad),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_bad(rd0_bad),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_bad(rd1_bad)
  );

  // Bench model: legality from the requirement text
  function automatic logic m_ok(logic [3:0] idx, logic [2:0] size, logic ext);
    if (size > 3'd4) return 1'b0;
    if (size == 3'd1 && (idx > 4'd3 || ext)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [63:0] m_read(logic [3:0] idx, logic [2:0] size, logic ext);
    logic [63:0] r;
    r = mdl[idx];
    if (!m_ok(idx, size, ext)) return 64'd0;
    case (size)
      3'd0: return r & 64'hFF;
      3'd1: return (r >> 8) & 64'hFF;
      3'd2: return r & 64'hFFFF;
      3'd3: return r & 64'hFFFF_FFFF;
      default: return r;
    endcase
  endfunction

  function automatic void m_write(logic [3:0] idx, logic [2:0] size, logic [63:0] d, logic ext);
    logic [63:0] mask;
    int sh;
    if (!m_ok(idx, size, ext)) return;
    sh = 0;
    case (size)
      3'd0: mask = 64'hFF;
      3'd1: begin mask = 64'hFF00; sh = 8; end
      3'd2: mask = 64'hFFFF;
      3'd3: begin mask = '1; d = d & 64'hFFFF_FFFF; end
      default: mask = '1;
    endcase
    mdl[idx] = (mdl[idx] & ~mask) | ((d << sh) & mask);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] idx, logic [2:0] size, logic [63:0] d, string tag);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_size = size; wr_data = d;
    #1;
    check({tag, " wr_bad"}, {63'd0, wr_bad}, {63'd0, !m_ok(idx, size, ext_form)});
    @(negedge clk);
    wr_en = 0;
    m_write(idx, size, d, ext_form);
  endtask

  task automatic rd0(logic [3:0] idx, logic [2:0] size, string tag);
    rd0_idx = idx; rd0_size = size;
    #1;
    check({tag, " rd0_data"}, rd0_data, m_read(idx, size, ext_form));
    check({tag, " rd0_bad"}, {63'd0, rd0_bad}, {63'd0, !m_ok(idx, size, ext_form)});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
  endtask

  task automatic t_reset();
    do_write(4'd7, 3'd4, 64'h1234_5678_9ABC_DEF0, "R2 preload");
    do_reset();
    for (int i = 0; i < 16; i++) rd0(4'(i), 3'd4, "R1 reset clear");
  endtask

  task automatic t_full64();
    do_write(4'd0, 3'd4, 64'hDEAD_BEEF_0123_4567, "R2");
    do_write(4'd15, 3'd4, 64'hFFFF_0000_FFFF_0000, "R2");
    rd0(4'd0, 3'd4, "R2 idx0");
    rd0(4'd15, 3'd4, "R2 idx15");
  endtask

  task automatic t_w32();
    do_write(4'd9, 3'd4, '1, "R3 preload");
    do_write(4'd9, 3'd3, 64'hAAAA_BBBB_CCCC_DDDD, "R3");
    rd0(4'd9, 3'd4, "R3 upper cleared");
    rd0(4'd9, 3'd3, "R3 read32");
  endtask

  task automatic t_w16();
    do_write(4'd4, 3'd4, 64'h1111_2222_3333_4444, "R4 preload");
    do_write(4'd4, 3'd2, 64'hFFFF_FFFF_FFFF_ABCD, "R4");
    rd0(4'd4, 3'd4, "R4 merge");
    rd0(4'd4, 3'd2, "R4 read16");
  endtask

  task automatic t_lo8();
    do_write(4'd12, 3'd4, 64'h0102_0304_0506_0708, "R5 preload");
    do_write(4'd12, 3'd0, 64'hFFFF_FFFF_FFFF_FF9E, "R5");
    rd0(4'd12, 3'd4, "R5 merge");
    rd0(4'd12, 3'd0, "R5 read8");
  endtask

  task automatic t_hi8();
    do_write(4'd2, 3'd4, 64'h7766_5544_3322_1100, "R6 preload");
    do_write(4'd2, 3'd1, 64'h0000_0000_0000_00AB, "R6");
    rd0(4'd2, 3'd4, "R6 merge");
    rd0(4'd2, 3'd1, "R6 read hi");
    do_write(4'd3, 3'd1, 64'h5A, "R6 idx3");
    rd0(4'd3, 3'd4, "R6 idx3 full");
  endtask

  task automatic t_hi_bad();
    do_write(4'd5, 3'd4, 64'hCAFE_F00D_CAFE_F00D, "R7 preload");
    do_write(4'd5, 3'd1, 64'h77, "R7");
    rd0(4'd5, 3'd4, "R7 unchanged");
    rd0(4'd5, 3'd1, "R7 read zero");
  endtask

  task automatic t_hi_ext();
    ext_form = 1;
    do_write(4'd1, 3'd1, 64'h99, "R8");
    rd0(4'd1, 3'd1, "R8 read zero");
    rd0(4'd1, 3'd0, "R8 lo8 still legal");
    ext_form = 0;
    rd0(4'd1, 3'd4, "R8 unchanged");
  endtask

  task automatic t_badsize();
    do_write(4'd6, 3'd4, 64'h0F0F_0F0F_0F0F_0F0F, "R9 preload");
    for (int s = 5; s < 8; s++) begin
      do_write(4'd6, 3'(s), 64'hFFFF, "R9");
      rd0(4'd6, 3'(s), "R9 read zero");
    end
    rd0(4'd6, 3'd4, "R9 unchanged");
  endtask

  task automatic t_same_cycle();
    do_write(4'd3, 3'd4, 64'h1, "R10 preload");
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd3; wr_size = 3'd4; wr_data = 64'h2;
    rd0_idx = 4'd3; rd0_size = 3'd4;
    #1;
    check("R10 old value", rd0_data, 64'h1);
    @(negedge clk);
    wr_en = 0;
    m_write(4'd3, 3'd4, 64'h2, 1'b0);
    rd0(4'd3, 3'd4, "R10 after");
  endtask

  task automatic t_noen();
    @(negedge clk);
    wr_en = 0; wr_idx = 4'd8; wr_size = 3'd4; wr_data = '1;
    #1;
    check("R11 wr_bad low", {63'd0, wr_bad}, 64'd0);
    @(negedge clk);
    rd0(4'd8, 3'd4, "R11 unchanged");
  endtask

  task automatic t_dual();
    do_write(4'd10, 3'd4, 64'h8877_6655_4433_2211, "R12 preload");
    rd0_idx = 4'd10; rd0_size = 3'd2;
    rd1_idx = 4'd11; rd1_size = 3'd1;
    #1;
    check("R12 port0 data", rd0_data, 64'h2211);
    check("R12 port1 bad", {63'd0, rd1_bad}, 64'd1);
    check("R12 port1 data", rd1_data, 64'd0);
    rd1_idx = 4'd10; rd1_size = 3'd3;
    #1;
    check("R12 port1 read32", rd1_data, 64'h4433_2211);
    check("R12 port0 bad", {63'd0, rd0_bad}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_full64();
    t_w32();
    t_w16();
    t_lo8();
    t_hi8();
    t_hi_bad();
    t_hi_ext();
    t_badsize();
    t_same_cycle();
    t_noen();
    t_dual();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule